// File: doc/BRIEF.md
# Segmented and Paged Address Translator

This block turns a 32-bit virtual address into a physical address by walking descriptor tables in memory. The two most significant address bits name one of four sections, and each section has its own segment table base held in a small register file that the processor writes. The next thirteen bits index that table to find an eight-byte segment descriptor. A flag in the descriptor makes the segment either contiguous, where the low seventeen address bits are added to a segment base after a length check, or paged, where those bits split into a page number and a page offset and one more descriptor word supplies the page frame.

A client presents an address on a valid/ready handshake. The walker then issues one to three word reads on a simple memory read port and returns a one-cycle response carrying either the physical address or a fault code. One translation is handled at a time. There is no descriptor cache and no protection checking beyond the valid bits.

Top module: `xlat_unit`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_rd_o` are 0.
- R2: Four table base registers reset to 0 and are written with `base_wdata_i` at the register chosen by `base_sel_i` when `base_we_i` is 1. A translation uses the register chosen by virtual address bits 31:30, sampled at acceptance.
- R3: The first read is at table base + (virtual address bits 29:17) * 8 (descriptor word 0). Word 0 bit 31 is the valid flag, bit 30 is the paged flag (1 = paged) and bits 16:0 are the maximum offset. If the walk continues, the second read is at that address + 4 (word 1, the segment or page table base).
- R4: A word 0 with bit 31 clear ends the walk after that single read, with fault code 1 (missing segment) and physical address 0.
- R5: In a contiguous segment, an offset (bits 16:0) greater than the maximum offset ends the walk after one read with fault code 3 (length) and physical address 0. An offset equal to the maximum is allowed.
- R6: A valid contiguous translation returns word 1 + offset, modulo 2^32, with code 0.
- R7: In a paged segment, the maximum offset is ignored, and the third read is at word 1 + (bits 16:11) * 4.
- R8: A page descriptor with bit 0 clear gives fault code 2 (missing page) and physical address 0.
- R9: A valid paged translation returns page descriptor bits 31:11 joined with virtual address bits 10:0, with code 0.
- R10: `req_ready_o` is low from the cycle after acceptance until the response has been given. `rsp_valid_o` is a one-cycle pulse, and ready returns in the next cycle. `rsp_fault_o` is 1 exactly when the code is not 0.
- R11: `mem_rd_o` is low while idle. Once raised, it stays high with a stable `mem_addr_o` until `mem_rvalid_i`, which is sampled together with `mem_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Table base register write strobe |
| base_sel_i | input | 2 | Section whose base register is written |
| base_wdata_i | input | 32 | Table base value to write |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |
| rsp_fault_o | output | 1 | Translation failed |
| rsp_code_o | output | 2 | 0 none, 1 missing segment, 2 missing page, 3 length |
| mem_rd_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor byte address |
| mem_rvalid_i | input | 1 | Read data valid, ends the read |
| mem_rdata_i | input | 32 | Read data |

## Verification
The assertions check every cycle that the handshake holds together: ready drops after acceptance, the response is a single pulse followed by ready, a pending read keeps its address, and no read is made while idle. They also check that faulted responses carry a zero address, that only contiguous walks end in a length fault, and that paged results keep the low eleven address bits and that the base registers change only when written. The correct descriptor addresses, the number of reads for each outcome, the offset boundary at the maximum, the wrap of base plus offset and the choice of section base can only be shown by the bench's scenarios. These scenarios compare against a model that reads the bench's own memory image.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SD0, ST_SD1, ST_PD, ST_RSP} walk_st_e;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEG  = 2'd1,
    FLT_PAGE = 2'd2,
    FLT_LEN  = 2'd3
  } flt_e;
  localparam int SD_VALID_BIT = 31;
  localparam int SD_PAGED_BIT = 30;
  localparam int PD_VALID_BIT = 0;
endpackage

// File: rtl/xlat_table_regs.sv
module xlat_table_regs #(
  parameter int DW    = 32,
  parameter int SID_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SID_W-1:0] wsel_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [SID_W-1:0] rsel_i,
  output logic [DW-1:0]    rbase_o
);
  localparam int NSEC = 1 << SID_W;

  logic [DW-1:0] base_q [NSEC];

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               base_q[g] <= '0;
      else if (we_i && wsel_i == SID_W'(g))      base_q[g] <= wdata_i;
    end

    AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && wsel_i == SID_W'(g)) |=> $stable(base_q[g])); // R2
  end

  assign rbase_o = base_q[rsel_i];
endmodule

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int DW     = 32,
  parameter int SEL_W  = 13,
  parameter int PSEL_W = 6,
  parameter int POFF_W = 11
) (
  input  logic [DW-1:0]                    tbase_i,
  input  logic [SEL_W+PSEL_W+POFF_W-1:0]   vaddr_i,
  input  logic [DW-1:0]                    sd1_i,
  input  logic [DW-1:0]                    word_i,
  output logic [DW-1:0]                    sd0_addr_o,
  output logic [DW-1:0]                    sd1_addr_o,
  output logic [DW-1:0]                    pd_addr_o,
  output logic [DW-1:0]                    contig_pa_o,
  output logic [DW-1:0]                    paged_pa_o,
  output logic                             len_over_o
);
  localparam int OFF_W = PSEL_W + POFF_W;

  logic [SEL_W-1:0]  seg_sel;
  logic [OFF_W-1:0]  seg_off;
  logic [PSEL_W-1:0] pg_sel;
  logic [POFF_W-1:0] pg_off;

  assign seg_sel = vaddr_i[OFF_W +: SEL_W];
  assign seg_off = vaddr_i[OFF_W-1:0];
  assign pg_sel  = vaddr_i[POFF_W +: PSEL_W];
  assign pg_off  = vaddr_i[POFF_W-1:0];

  // descriptors are two words, page entries one word
  assign sd0_addr_o  = tbase_i + (DW'(seg_sel) << 3);
  assign sd1_addr_o  = sd0_addr_o + DW'(4);
  assign pd_addr_o   = sd1_i + (DW'(pg_sel) << 2);
  assign contig_pa_o = word_i + DW'(seg_off);
  assign paged_pa_o  = {word_i[DW-1:POFF_W], pg_off};
  assign len_over_o  = seg_off > word_i[OFF_W-1:0];
endmodule

// File: rtl/xlat_walk_ctrl.sv
module xlat_walk_ctrl
  import xlat_pkg::*;
#(
  parameter int DW     = 32,
  parameter int LVA_W  = 30,
  parameter int POFF_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [LVA_W-1:0] req_vaddr_i,
  input  logic [DW-1:0]    tbase_i,
  output logic             rsp_valid_o,
  output logic [DW-1:0]    rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_code_o,
  output logic             mem_rd_o,
  output logic [DW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [LVA_W-1:0] vaddr_q_o,
  output logic [DW-1:0]    tbase_q_o,
  output logic [DW-1:0]    sd1_q_o,
  input  logic [DW-1:0]    sd0_addr_i,
  input  logic [DW-1:0]    sd1_addr_i,
  input  logic [DW-1:0]    pd_addr_i,
  input  logic [DW-1:0]    contig_pa_i,
  input  logic [DW-1:0]    paged_pa_i,
  input  logic             len_over_i
);
  walk_st_e         st_q;
  logic [LVA_W-1:0] vaddr_q;
  logic [DW-1:0]    tbase_q, sd1_q, paddr_q;
  logic             paged_q;
  flt_e             code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      vaddr_q <= '0;
      tbase_q <= '0;
      sd1_q   <= '0;
      paged_q <= 1'b0;
      paddr_q <= '0;
      code_q  <= FLT_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          tbase_q <= tbase_i;
          st_q    <= ST_SD0;
        end
        ST_SD0: if (mem_rvalid_i) begin
          paged_q <= mem_rdata_i[SD_PAGED_BIT];
          if (!mem_rdata_i[SD_VALID_BIT]) begin
            code_q  <= FLT_SEG;
            paddr_q <= '0;
            st_q    <= ST_RSP;
          end else if (!mem_rdata_i[SD_PAGED_BIT] && len_over_i) begin
            code_q  <= FLT_LEN;
            paddr_q <= '0;
            st_q    <= ST_RSP;
          end else begin
            st_q    <= ST_SD1;
          end
        end
        ST_SD1: if (mem_rvalid_i) begin
          sd1_q <= mem_rdata_i;
          if (paged_q) begin
            st_q <= ST_PD;
          end else begin
            paddr_q <= contig_pa_i;
            code_q  <= FLT_NONE;
            st_q    <= ST_RSP;
          end
        end
        ST_PD: if (mem_rvalid_i) begin
          if (!mem_rdata_i[PD_VALID_BIT]) begin
            code_q  <= FLT_PAGE;
            paddr_q <= '0;
          end else begin
            code_q  <= FLT_NONE;
            paddr_q <= paged_pa_i;
          end
          st_q <= ST_RSP;
        end
        ST_RSP:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_SD0:  mem_addr_o = sd0_addr_i;
      ST_SD1:  mem_addr_o = sd1_addr_i;
      ST_PD:   mem_addr_o = pd_addr_i;
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_rd_o    = (st_q == ST_SD0) || (st_q == ST_SD1) || (st_q == ST_PD);
  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RSP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_code_o  = code_q;
  assign rsp_fault_o = (code_q != FLT_NONE);
  assign vaddr_q_o   = vaddr_q;
  assign tbase_q_o   = tbase_q;
  assign sd1_q_o     = sd1_q;

  AST_BUSY_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R10
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o)); // R10
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_rvalid_i) |=> (mem_rd_o && $stable(mem_addr_o))); // R11
  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_rd_o); // R11
  AST_FAULT_ZERO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0)); // R4
  AST_LEN_ONLY_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == FLT_LEN) |-> !paged_q); // R7
  AST_PAGE_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o && paged_q)
      |-> (rsp_paddr_o[POFF_W-1:0] == vaddr_q[POFF_W-1:0])); // R9
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
  parameter int DW     = 32,
  parameter int SID_W  = 2,
  parameter int SEL_W  = 13,
  parameter int PSEL_W = 6,
  parameter int POFF_W = 11
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   base_we_i,
  input  logic [SID_W-1:0]                       base_sel_i,
  input  logic [DW-1:0]                          base_wdata_i,
  input  logic                                   req_valid_i,
  output logic                                   req_ready_o,
  input  logic [SID_W+SEL_W+PSEL_W+POFF_W-1:0]   req_vaddr_i,
  output logic                                   rsp_valid_o,
  output logic [DW-1:0]                          rsp_paddr_o,
  output logic                                   rsp_fault_o,
  output logic [1:0]                             rsp_code_o,
  output logic                                   mem_rd_o,
  output logic [DW-1:0]                          mem_addr_o,
  input  logic                                   mem_rvalid_i,
  input  logic [DW-1:0]                          mem_rdata_i
);
  localparam int LVA_W = SEL_W + PSEL_W + POFF_W;
  localparam int VA_W  = SID_W + LVA_W;

  logic [DW-1:0]    tbase_sel, tbase_q, sd1_q;
  logic [LVA_W-1:0] vaddr_q;
  logic [DW-1:0]    sd0_addr, sd1_addr, pd_addr, contig_pa, paged_pa;
  logic             len_over;

  xlat_table_regs #(.DW(DW), .SID_W(SID_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .wsel_i  (base_sel_i),
    .wdata_i (base_wdata_i),
    .rsel_i  (req_vaddr_i[VA_W-1 -: SID_W]),
    .rbase_o (tbase_sel)
  );

  xlat_addr_gen #(.DW(DW), .SEL_W(SEL_W), .PSEL_W(PSEL_W), .POFF_W(POFF_W)) u_agen (
    .tbase_i     (tbase_q),
    .vaddr_i     (vaddr_q),
    .sd1_i       (sd1_q),
    .word_i      (mem_rdata_i),
    .sd0_addr_o  (sd0_addr),
    .sd1_addr_o  (sd1_addr),
    .pd_addr_o   (pd_addr),
    .contig_pa_o (contig_pa),
    .paged_pa_o  (paged_pa),
    .len_over_o  (len_over)
  );

  xlat_walk_ctrl #(.DW(DW), .LVA_W(LVA_W), .POFF_W(POFF_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_vaddr_i  (req_vaddr_i[LVA_W-1:0]),
    .tbase_i      (tbase_sel),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_fault_o  (rsp_fault_o),
    .rsp_code_o   (rsp_code_o),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .vaddr_q_o    (vaddr_q),
    .tbase_q_o    (tbase_q),
    .sd1_q_o      (sd1_q),
    .sd0_addr_i   (sd0_addr),
    .sd1_addr_i   (sd1_addr),
    .pd_addr_i    (pd_addr),
    .contig_pa_i  (contig_pa),
    .paged_pa_i   (paged_pa),
    .len_over_i   (len_over)
  );
endmodule

// File: tb/xlat_unit_test.sv
`timescale 1ns/1ps
module xlat_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [1:0]  base_sel = '0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_code;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  xlat_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .base_we_i(base_we), .base_sel_i(base_sel), .base_wdata_i(base_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .rsp_code_o(rsp_code), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] base_m [4];
  logic [31:0] rd_log [8];
  int rd_n = 0;
  int wait_cnt = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory responder: 0..2 wait cycles per read, data on rvalid
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd && rst_n) begin
        if (wait_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd(mem_addr);
          if (rd_n < 8) rd_log[rd_n] = mem_addr;
          rd_n++;
          wait_cnt = int'($urandom % 3);
        end else begin
          mem_rvalid = 1'b0;
          wait_cnt--;
        end
      end else begin
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic model(input logic [31:0] va, output logic [1:0] code, output logic [31:0] pa,
                       output int n, output logic [31:0] a0, output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] w0, w1, pd;
    a0 = base_m[va[31:30]] + {16'h0, va[29:17], 3'b000};
    a1 = a0 + 32'd4;
    a2 = 32'h0;
    pa = 32'h0;
    w0 = rd(a0);
    n = 1;
    if (!w0[31]) code = 2'd1;
    else if (!w0[30] && (va[16:0] > w0[16:0])) code = 2'd3;
    else begin
      w1 = rd(a1);
      n = 2;
      if (!w0[30]) begin
        code = 2'd0;
        pa = w1 + {15'h0, va[16:0]};
      end else begin
        a2 = w1 + {24'h0, va[16:11], 2'b00};
        pd = rd(a2);
        n = 3;
        if (!pd[0]) code = 2'd2;
        else begin
          code = 2'd0;
          pa = {pd[31:11], va[10:0]};
        end
      end
    end
  endtask

  task automatic write_base(input int k, input logic [31:0] v);
    @(negedge clk);
    base_we = 1'b1; base_sel = 2'(k); base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    base_m[k] = v;
  endtask

  task automatic run_xlat(input logic [31:0] va, input string tag);
    logic [1:0]  e_code;
    logic [31:0] e_pa, e_a0, e_a1, e_a2;
    int e_n, cyc;
    bit busy_bad;
    logic [31:0] g_pa;
    logic [1:0]  g_code;
    logic        g_fault;
    model(va, e_code, e_pa, e_n, e_a0, e_a1, e_a2);
    rd_n = 0;
    busy_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 100) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      cyc++;
    end
    if (req_ready) busy_bad = 1;
    check(rsp_valid, {tag, " R10 response arrives"}, 32'(rsp_valid), 32'd1);
    check(!busy_bad, {tag, " R10 ready low while busy"}, 32'(busy_bad), 32'd0);
    g_pa = rsp_paddr; g_code = rsp_code; g_fault = rsp_fault;
    check(g_code == e_code, {tag, " R4/R5/R8 fault code"}, 32'(g_code), 32'(e_code));
    check(g_pa == e_pa, {tag, " R6/R9 physical address"}, g_pa, e_pa);
    check(g_fault == (e_code != 2'd0), {tag, " R10 fault flag"}, 32'(g_fault), 32'(e_code != 2'd0));
    check(rd_n == e_n, {tag, " R3/R7 read count"}, 32'(rd_n), 32'(e_n));
    if (rd_n >= 1) check(rd_log[0] == e_a0, {tag, " R3 word0 address"}, rd_log[0], e_a0);
    if (rd_n >= 2 && e_n >= 2) check(rd_log[1] == e_a1, {tag, " R3 word1 address"}, rd_log[1], e_a1);
    if (rd_n >= 3 && e_n >= 3) check(rd_log[2] == e_a2, {tag, " R7 page entry address"}, rd_log[2], e_a2);
    @(negedge clk);
    check(req_ready && !rsp_valid, {tag, " R10 one-cycle pulse then ready"},
          {30'h0, req_ready, rsp_valid}, 32'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] sd_a, w0;
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) base_m[k] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid === 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
    check(mem_rd === 1'b0, "R1 no read after reset", 32'(mem_rd), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_rd, "R1 idle after reset release", {30'h0, req_ready, mem_rd}, 32'h2);

    // R2/R4: bases still 0, empty memory gives missing segment at address 0 + sel*8
    run_xlat(32'hC000_0000, "r2_base_zero");
    run_xlat(32'h4006_0000, "r4_missing_seg");

    // program bases and random descriptor tables
    for (int k = 0; k < 4; k++)
      write_base(k, 32'h0010_0000 * (k + 1) + 32'h1000 + 32'd8 * ($urandom % 16));
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 8; s++) begin
        logic [31:0] ptb;
        sd_a = base_m[k] + 32'(s * 8);
        w0 = $urandom;
        w0[31] = ($urandom % 100) < 85;
        if (($urandom % 4) == 0) w0[16:0] = 17'h1FFFF;
        mem_img[sd_a] = w0;
        ptb = 32'h0800_0000 + 32'((k * 8 + s) * 256);
        mem_img[sd_a + 4] = w0[30] ? ptb : $urandom;
        if (w0[30])
          for (int p = 0; p < 64; p++) begin
            logic [31:0] pdw;
            pdw = $urandom;
            pdw[0] = ($urandom % 100) < 80;
            mem_img[ptb + 32'(p * 4)] = pdw;
          end
      end
    end

    // directed contiguous segment: section 1, select 100, max 0x100, base wraps
    sd_a = base_m[1] + 32'd800;
    mem_img[sd_a]     = 32'h8000_0100;
    mem_img[sd_a + 4] = 32'hFFFF_FF80;
    run_xlat({2'd1, 13'd100, 17'h00100}, "r5_offset_eq_max_r6_wrap");
    run_xlat({2'd1, 13'd100, 17'h00101}, "r5_offset_over_max");
    run_xlat({2'd1, 13'd100, 17'h00000}, "r6_offset_zero");

    // directed paged segment: section 2, select 200, max 0 ignored
    sd_a = base_m[2] + 32'd1600;
    mem_img[sd_a]     = 32'hC000_0000;
    mem_img[sd_a + 4] = 32'h0900_0000;
    mem_img[32'h0900_0000 + 32'd20] = 32'h1234_5000;   // page 5 invalid
    mem_img[32'h0900_0000 + 32'd24] = 32'hABCD_E801;   // page 6 valid
    run_xlat({2'd2, 13'd200, 6'd5, 11'h123}, "r8_missing_page");
    run_xlat({2'd2, 13'd200, 6'd6, 11'h7FF}, "r7_r9_paged_max_ignored");
    run_xlat({2'd2, 13'd200, 6'd63, 11'h000}, "r9_unmapped_page_entry");

    // R2: base rewrite redirects later walks
    write_base(3, 32'h00F0_0000);
    mem_img[32'h00F0_0000 + 32'd8] = 32'h8000_0FFF;
    mem_img[32'h00F0_0000 + 32'd12] = 32'h0000_4000;
    run_xlat({2'd3, 13'd1, 17'h00ABC}, "r2_rewritten_base");

    // random mix over all sections and outcomes
    for (int i = 0; i < 400; i++) begin
      logic [31:0] va;
      va = $urandom;
      va[29:17] = 13'($urandom % 10);
      run_xlat(va, "rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule